// File: doc/BRIEF.md
# Dual-Protocol Handshake Elastic Buffer

This block sits between a producing pipeline stage and a consuming one and soaks up short-term mismatches in their rates. When the producer has a word but the consumer is busy, the word waits in the buffer, so the producer is not blocked. When the consumer is ready but the producer has nothing new, a stored word can still go out, so the consumer does not starve. Both ports use a request/acknowledge handshake. A static mode pin sets the signalling style for both ports. In transition signalling, every edge of a request marks one transfer. In return-to-zero signalling, a transfer takes four edges.

The buffer is built as clocked logic that samples the handshake wires on each rising clock edge. Inside, a ring of slots is addressed by a wrapping write pointer and a wrapping read pointer. In front of the consumer sits one output stage. If the ring is empty and that stage is free, an accepted word is loaded straight into the output stage and never touches a ring slot. The ring depth and the word width are independent parameters. Changing either one leaves the control logic unchanged.

Top module: `hs_elastic_buf`

## Requirements
- R1: With `four_phase` low, a transfer is pending on a port whenever its request differs from its acknowledge. The buffer answers each accepted upstream transfer with exactly one toggle of `up_ack`, and it never toggles `up_ack` while `up_req` equals `up_ack`.
- R2: With `four_phase` high, an upstream word is taken when `up_req` is high and `up_ack` is low. `up_ack` then rises one clock edge later. It stays high while `up_req` stays high, and it falls on the first edge after `up_req` has gone low. No new word is accepted while `up_ack` is high.
- R3: Words leave on `dn_data` in exactly the order they were accepted on `up_data`, in both modes and for any downstream stall pattern.
- R4: If the ring is empty and the output stage is idle, an accepted word appears on `dn_data` at the same clock edge that acknowledges it, and `dn_req` is raised (four-phase) or toggled (two-phase) at that same edge.
- R5: Once all `SLOTS` ring slots and the output stage hold words, an offered word is not acknowledged until the consumer completes a transfer. The buffer therefore accepts exactly `SLOTS`+1 words against a fully stalled consumer.
- R6: The ring occupancy never exceeds `SLOTS`. A store and a fetch at the same edge leave it unchanged.
- R7: `dn_data` stays constant while a downstream transfer is outstanding. In two-phase mode that is while `dn_req` differs from `dn_ack`. In four-phase mode it is while either `dn_req` or `dn_ack` is high.
- R8: A synchronous reset (`rst` high at a clock edge) empties the ring and drives `up_ack` and `dn_req` low. Words held before the reset are never delivered afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| four_phase | input | 1 | 0: transition signalling, 1: return-to-zero signalling (static) |
| up_req | input | 1 | Producer request |
| up_data | input | DATA_W | Producer word |
| up_ack | output | 1 | Acknowledge to producer |
| dn_req | output | 1 | Request to consumer |
| dn_data | output | DATA_W | Word presented to consumer |
| dn_ack | input | 1 | Consumer acknowledge |

## Verification
The hardest state to reach from the ports is a completely full buffer: every ring slot holds a word, the output stage is occupied, and one more word sits pending at the input. Only in that state do the withheld acknowledge and the following store-plus-fetch edge both show up. The bench reaches it by holding the consumer stalled, sending `SLOTS`+1 complete transfers, and then offering one more word that must stay unanswered for several cycles. It then releases the consumer and checks that the late word is admitted in order. A pseudo-random stall pattern on the consumer, run in both modes, exercises stores and fetches that land on the same edge.

// File: rtl/hs_eb_pkg.sv
package hs_eb_pkg;

   typedef enum logic {
      HS_TWO_PHASE  = 1'b0,
      HS_FOUR_PHASE = 1'b1
   } hs_mode_e;

   // a new word waits at a receiving port
   function automatic logic hs_word_waiting(hs_mode_e m, logic req, logic ack);
      return (m == HS_FOUR_PHASE) ? (req & ~ack) : (req ^ ack);
   endfunction

   // a sending port has finished its last transfer and may launch another
   function automatic logic hs_port_idle(hs_mode_e m, logic req, logic ack);
      return (m == HS_FOUR_PHASE) ? (~req & ~ack) : ~(req ^ ack);
   endfunction

endpackage

// File: rtl/hs_eb_inport.sv
module hs_eb_inport
   import hs_eb_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  hs_mode_e mode,
   input  logic     req,
   input  logic     take,
   output logic     waiting,
   output logic     ack
);

   assign waiting = hs_word_waiting(mode, req, ack);

   always_ff @(posedge clk) begin
      if (rst) begin
         ack <= 1'b0;
      end else if (take) begin
         ack <= (mode == HS_FOUR_PHASE) ? 1'b1 : ~ack;
      end else if (mode == HS_FOUR_PHASE && ack && !req) begin
         ack <= 1'b0;
      end
   end

endmodule

// File: rtl/hs_eb_outport.sv
module hs_eb_outport
   import hs_eb_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst,
   input  hs_mode_e          mode,
   input  logic              launch,
   input  logic [DATA_W-1:0] launch_data,
   input  logic              ack,
   output logic              idle,
   output logic              req,
   output logic [DATA_W-1:0] data
);

   assign idle = hs_port_idle(mode, req, ack);

   always_ff @(posedge clk) begin
      if (rst) begin
         req  <= 1'b0;
         data <= '0;
      end else if (launch) begin
         data <= launch_data;
         req  <= (mode == HS_FOUR_PHASE) ? 1'b1 : ~req;
      end else if (mode == HS_FOUR_PHASE && req && ack) begin
         req <= 1'b0;
      end
   end

endmodule

// File: rtl/hs_eb_ring.sv
module hs_eb_ring #(
   parameter int DATA_W = 8,
   parameter int SLOTS  = 4,
   localparam int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int CW    = $clog2(SLOTS + 1)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              store,
   input  logic [DATA_W-1:0] store_data,
   input  logic              fetch,
   output logic [DATA_W-1:0] head_data,
   output logic [CW-1:0]     occ,
   output logic              empty,
   output logic              full
);

   localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

   logic [DATA_W-1:0] slot_q [SLOTS];
   logic [PW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if ((SLOTS & (SLOTS - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign head_data = slot_q[rd_ptr];
   assign empty     = (occ == '0);
   assign full      = (occ == CW'(SLOTS));

   always_ff @(posedge clk) begin
      if (store) slot_q[wr_ptr] <= store_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (store) wr_ptr <= wr_nxt;
         if (fetch) rd_ptr <= rd_nxt;
         case ({store, fetch})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

endmodule

// File: rtl/hs_elastic_buf.sv
module hs_elastic_buf
   import hs_eb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SLOTS  = 4,
   localparam int CW    = $clog2(SLOTS + 1)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              four_phase,
   input  logic              up_req,
   input  logic [DATA_W-1:0] up_data,
   output logic              up_ack,
   output logic              dn_req,
   output logic [DATA_W-1:0] dn_data,
   input  logic              dn_ack
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hs_elastic_buf: DATA_W must be at least 1");
      end
      if (SLOTS < 2) begin : g_bad_depth
         $error("hs_elastic_buf: SLOTS must be at least 2");
      end
   endgenerate

   hs_mode_e          mode;
   logic              in_waiting, in_take;
   logic              out_idle, out_launch;
   logic              ring_store, ring_fetch, ring_empty, ring_full;
   logic              bypass;
   logic [DATA_W-1:0] ring_head, launch_word;
   logic [CW-1:0]     occ;

   assign mode        = hs_mode_e'(four_phase);
   assign in_take     = in_waiting & ~ring_full;
   assign bypass      = in_take & ring_empty & out_idle;
   assign ring_fetch  = out_idle & ~ring_empty;
   assign ring_store  = in_take & ~bypass;
   assign out_launch  = bypass | ring_fetch;
   assign launch_word = ring_fetch ? ring_head : up_data;

   hs_eb_inport u_in (
      .clk(clk), .rst(rst), .mode(mode), .req(up_req),
      .take(in_take), .waiting(in_waiting), .ack(up_ack)
   );

   hs_eb_ring #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_ring (
      .clk(clk), .rst(rst), .store(ring_store), .store_data(up_data),
      .fetch(ring_fetch), .head_data(ring_head), .occ(occ),
      .empty(ring_empty), .full(ring_full)
   );

   hs_eb_outport #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst(rst), .mode(mode), .launch(out_launch),
      .launch_data(launch_word), .ack(dn_ack), .idle(out_idle),
      .req(dn_req), .data(dn_data)
   );

endmodule

// File: rtl/hs_eb_checker.sv
module hs_eb_checker #(
   parameter int DATA_W = 8,
   parameter int SLOTS  = 4,
   localparam int CW    = $clog2(SLOTS + 1)
)(
   input logic              clk,
   input logic              rst,
   input logic              four_phase,
   input logic              up_req,
   input logic              up_ack,
   input logic              dn_req,
   input logic              dn_ack,
   input logic [DATA_W-1:0] dn_data,
   input logic [CW-1:0]     occ,
   input logic              full
);

   logic dn_busy;
   assign dn_busy = four_phase ? (dn_req | dn_ack) : (dn_req ^ dn_ack);

   // R6
   a_r6_occ_bound: assert property (@(posedge clk) disable iff (rst)
      occ <= CW'(SLOTS));

   // R5
   a_r5_full_two: assert property (@(posedge clk) disable iff (rst)
      (!four_phase && full) |=> $stable(up_ack));

   // R5
   a_r5_full_four: assert property (@(posedge clk) disable iff (rst)
      (four_phase && full && !up_ack) |=> !up_ack);

   // R1
   a_r1_no_spurious_toggle: assert property (@(posedge clk) disable iff (rst)
      (!four_phase && (up_req == up_ack)) |=> $stable(up_ack));

   // R2
   a_r2_ack_held: assert property (@(posedge clk) disable iff (rst)
      (four_phase && up_ack && up_req) |=> up_ack);

   // R2
   a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
      (four_phase && !up_ack && !up_req) |=> !up_ack);

   // R7
   a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
      dn_busy |=> $stable(dn_data));

   // R8
   a_r8_reset_idle: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!up_ack && !dn_req && occ == '0));

endmodule

bind hs_elastic_buf hs_eb_checker #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_chk (
   .clk(clk), .rst(rst), .four_phase(four_phase), .up_req(up_req),
   .up_ack(up_ack), .dn_req(dn_req), .dn_ack(dn_ack), .dn_data(dn_data),
   .occ(occ), .full(ring_full)
);

// File: tb/hs_elastic_buf_test.sv
module hs_elastic_buf_test;

   localparam int DW = 8;
   localparam int NS = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          four_phase = 1'b0;
   logic          up_req = 1'b0;
   logic [DW-1:0] up_data = '0;
   logic          up_ack;
   logic          dn_req;
   logic [DW-1:0] dn_data;
   logic          dn_ack = 1'b0;

   int vectors = 0;
   int miscompares = 0;
   int stall_mode = 0;   // 0 never, 1 always, 2 pseudo-random
   int cyc = 0;
   logic [DW-1:0] exp_q [$];

   always #2 clk = ~clk;   // 250 MHz

   hs_elastic_buf #(.DATA_W(DW), .SLOTS(NS)) uut (
      .clk(clk), .rst(rst), .four_phase(four_phase), .up_req(up_req),
      .up_data(up_data), .up_ack(up_ack), .dn_req(dn_req),
      .dn_data(dn_data), .dn_ack(dn_ack)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   task automatic do_reset(input logic fp);
      @(negedge clk);
      rst = 1'b1;
      four_phase = fp;
      up_req = 1'b0;
      dn_ack = 1'b0;
      exp_q.delete();
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic offer(input logic [DW-1:0] w);
      up_data = w;
      exp_q.push_back(w);
      if (four_phase) up_req = 1'b1;
      else            up_req = ~up_req;
   endtask

   task automatic finish_xfer();
      if (!four_phase) begin
         while (up_ack != up_req) @(negedge clk);
      end else begin
         while (!up_ack) @(negedge clk);
         up_req = 1'b0;
         while (up_ack) @(negedge clk);
      end
   endtask

   task automatic send(input logic [DW-1:0] w);
      offer(w);
      @(negedge clk);
      finish_xfer();
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // consumer + scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (!rst) begin
            logic stall;
            case (stall_mode)
               0:       stall = 1'b0;
               1:       stall = 1'b1;
               default: stall = (((cyc * 7) ^ (cyc >> 2)) % 5) < 2;
            endcase
            if (!four_phase) begin
               if ((dn_req != dn_ack) && !stall) begin
                  if (exp_q.size() == 0) chk("R3 unexpected word", 32'(dn_data), 32'hFFFF_FFFF);
                  else chk("R3 order", 32'(dn_data), 32'(exp_q.pop_front()));
                  dn_ack = ~dn_ack;
               end
            end else begin
               if (dn_req && !dn_ack && !stall) begin
                  if (exp_q.size() == 0) chk("R3 unexpected word", 32'(dn_data), 32'hFFFF_FFFF);
                  else chk("R3 order", 32'(dn_data), 32'(exp_q.pop_front()));
                  dn_ack = 1'b1;
               end else if (!dn_req && dn_ack) begin
                  dn_ack = 1'b0;
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL R3 watchdog: actual=hung expected=completion");
      report();
   end

   task automatic full_stall_test(input logic [DW-1:0] base);
      logic [DW-1:0] held;
      logic          ack_before;
      stall_mode = 1;
      for (int i = 0; i <= NS; i++) send(base + DW'(i));
      chk("R5 capacity SLOTS+1 accepted", 32'(exp_q.size()), 32'(NS + 1));
      held = dn_data;
      ack_before = up_ack;
      offer(base + DW'(NS + 1));
      repeat (6) @(negedge clk);
      chk("R5 ack withheld when full", 32'(up_ack), 32'(ack_before));
      chk("R7 output stable while stalled", 32'(dn_data), 32'(held));
      stall_mode = 0;
      finish_xfer();
      drain();
      chk("R3 full-test words drained", 32'(exp_q.size()), 0);
   endtask

   task automatic stream_test(input int n, input logic [DW-1:0] seed);
      stall_mode = 2;
      for (int i = 0; i < n; i++) send(seed ^ DW'(i * 37));
      stall_mode = 0;
      drain();
      chk("R6 stream store/fetch lost nothing", 32'(exp_q.size()), 0);
   endtask

   initial begin
      logic [DW-1:0] held;
      // ---------- two-phase ----------
      do_reset(1'b0);
      chk("R8 up_ack low after reset", 32'(up_ack), 0);
      chk("R8 dn_req low after reset", 32'(dn_req), 0);

      stall_mode = 1;
      offer(8'hA5);
      @(negedge clk);
      chk("R4 pass-through data", 32'(dn_data), 32'hA5);
      chk("R4 dn_req toggled", 32'(dn_req), 1);
      chk("R1 single ack toggle", 32'(up_ack), 32'(up_req));
      held = dn_data;
      repeat (3) @(negedge clk);
      chk("R7 dn_data held", 32'(dn_data), 32'(held));
      chk("R1 no extra toggle", 32'(up_ack), 32'(up_req));
      stall_mode = 0;
      drain();

      full_stall_test(8'h10);
      stream_test(40, 8'h3C);

      // ---------- four-phase ----------
      do_reset(1'b1);
      chk("R8 up_ack low after reset (4ph)", 32'(up_ack), 0);
      chk("R8 dn_req low after reset (4ph)", 32'(dn_req), 0);

      stall_mode = 1;
      offer(8'h5A);
      @(negedge clk);
      chk("R2 ack rises", 32'(up_ack), 1);
      chk("R4 pass-through data (4ph)", 32'(dn_data), 32'h5A);
      chk("R4 dn_req raised (4ph)", 32'(dn_req), 1);
      repeat (2) @(negedge clk);
      chk("R2 ack held while req high", 32'(up_ack), 1);
      up_req = 1'b0;
      @(negedge clk);
      chk("R2 ack falls after req falls", 32'(up_ack), 0);
      chk("R7 dn_data held (4ph)", 32'(dn_data), 32'h5A);
      stall_mode = 0;
      drain();

      full_stall_test(8'h80);
      stream_test(40, 8'hC3);

      // ---------- reset flushes buffered words ----------
      stall_mode = 1;
      send(8'h01);
      send(8'h02);
      send(8'h03);
      do_reset(1'b1);
      chk("R8 up_ack low after flush", 32'(up_ack), 0);
      chk("R8 dn_req low after flush", 32'(dn_req), 0);
      stall_mode = 0;
      repeat (4) @(negedge clk);
      chk("R8 no stale word delivered", 32'(dn_req), 0);
      send(8'h77);
      drain();
      chk("R8 fresh word passes after flush", 32'(exp_q.size()), 0);

      report();
   end

endmodule